// File: doc/BRIEF.md
# Hex Record Stream Loader

This block takes a stream of ASCII characters, one per cycle when `char_valid` is high, and decodes load records from it. The decoded words go into a word memory through a single write port. A load has three parts. First comes a header line that gives the first memory location and the number of words to load. Next come as many data lines as that count needs, each holding four words written as hex digits. Last comes a trailer line that gives the program's start address and a trace flag.

Each group of eight hex digits becomes one 32-bit word, with the first digit as the most significant nibble. Words go to consecutive locations, starting at the header's location. When the trailer line ends, the loader raises a one-cycle done strobe and presents the start address and trace flag. Both values are held until the next good trailer.

Each detected fault produces a one-cycle error strobe with a code. After a fault, the loader skips the rest of the faulty line and then expects a new header. Several loads can therefore follow each other in one stream.

Top module: `hexrec_loader`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `mem_we`, `done` and `err_valid` are 0, and `start_addr` and `trace_flag` are 0.
- R2: The header line is two hex digits of location, one blank (0x20), two hex digits of length, then line feed (0x0A). The word with index i in the stream is written to address location+i.
- R3: Eight consecutive hex digits form one word, with the first digit in bits 31:28. Digits 0-9, A-F and a-f are all accepted.
- R4: Only the first `length` words are written. Padding words after them are decoded but not written. The number of data lines is ceil(length/4). A length of 0 goes straight to the trailer.
- R5: A carriage return (0x0D) is ignored anywhere in the stream, including in the middle of a data line.
- R6: The trailer line is two hex digits of start address, one blank, one flag digit, then line feed. On that line feed, `done` pulses for exactly one cycle and `start_addr` and `trace_flag` take the new values. Outside such a pulse they do not change.
- R7: A character that is not hex where a digit is expected raises error code 1.
- R8: A line feed where a digit is expected, or any other character where a blank or line feed is expected, raises error code 2.
- R9: If location+length is greater than 256, error code 3 is raised on the header's line feed and no word of that load is written. A sum of exactly 256 is accepted.
- R10: A trace-flag digit other than 0 or 1 raises error code 4, and no `done` pulse follows.
- R11: After an error, characters are discarded up to and including the next line feed, and the next line is parsed as a header. If the error was raised on a line feed, the very next line is a header.
- R12: `mem_we` is high in the cycle after the eighth digit of a word is accepted, and in no cycle that does not follow an accepted character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_valid | input | 1 | Character present on `char_data` this cycle |
| char_data | input | 8 | ASCII character |
| mem_we | output | 1 | Word memory write enable |
| mem_addr | output | 8 | Word memory write address |
| mem_wdata | output | 32 | Word memory write data |
| done | output | 1 | One-cycle pulse at the end of a good trailer |
| start_addr | output | 8 | Start address from the last good trailer |
| trace_flag | output | 1 | Trace flag from the last good trailer |
| err_valid | output | 1 | One-cycle error pulse |
| err_code | output | 3 | Code of the last error: 1 bad character, 2 format, 3 too large, 4 bad trace flag |

## Verification
The bench builds the loader with its default parameters: 32-bit words, four words per data line and two-digit fields, which gives a 256-word address space. With these values it can load right up to the top of memory (location F8, length 8). It can also reach the first sum past the top (location F9, length 8), a length that is not a multiple of four so that padding words must be dropped, and a zero length. Every error code is then followed by a good load in the same stream, which shows where parsing resumes.

// File: rtl/hexrec_loader_pkg.sv
`timescale 1ns/1ps
package hexrec_loader_pkg;

  // Parser position within the record stream
  typedef enum logic [3:0] {
    ST_HLOC  = 4'd0,
    ST_HSEP  = 4'd1,
    ST_HLEN  = 4'd2,
    ST_HEOL  = 4'd3,
    ST_DATA  = 4'd4,
    ST_DEOL  = 4'd5,
    ST_TADR  = 4'd6,
    ST_TSEP  = 4'd7,
    ST_TFLG  = 4'd8,
    ST_TEOL  = 4'd9,
    ST_DRAIN = 4'd10
  } ld_state_e;

  // Error codes reported on err_code
  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_BADCHAR = 3'd1,
    ERR_FORMAT  = 3'd2,
    ERR_SIZE    = 3'd3,
    ERR_TRACE   = 3'd4
  } ld_err_e;

  localparam logic [7:0] CH_LF    = 8'h0A;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_BLANK = 8'h20;

endpackage

// File: rtl/loader_char_class.sv
`timescale 1ns/1ps
module loader_char_class
  import hexrec_loader_pkg::*;
(
  input  logic [7:0] ch,
  output logic       is_hex,
  output logic [3:0] nib,
  output logic       is_lf,
  output logic       is_cr,
  output logic       is_blank
);
  logic is_dec, is_up, is_lo;
  logic [7:0] off;

  always_comb begin
    is_dec = (ch >= 8'h30) && (ch <= 8'h39);
    is_up  = (ch >= 8'h41) && (ch <= 8'h46);
    is_lo  = (ch >= 8'h61) && (ch <= 8'h66);
    if (is_dec)     off = ch - 8'h30;
    else if (is_up) off = ch - 8'h37;
    else            off = ch - 8'h57;
    is_hex   = is_dec | is_up | is_lo;
    nib      = off[3:0];
    is_lf    = (ch == CH_LF);
    is_cr    = (ch == CH_CR);
    is_blank = (ch == CH_BLANK);
  end
endmodule

// File: rtl/loader_nibble_shift.sv
`timescale 1ns/1ps
module loader_nibble_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic [3:0]   nib,
  output logic [W-1:0] acc_next
);
  logic [W-1:0] acc_q;

  generate
    if (W > 4) begin : g_wide
      assign acc_next = {acc_q[W-5:0], nib};
    end else begin : g_single
      assign acc_next = W'(nib);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           acc_q <= '0;
    else if (shift_en) acc_q <= acc_next;
  end
endmodule

// File: rtl/hexrec_loader.sv
`timescale 1ns/1ps
module hexrec_loader
  import hexrec_loader_pkg::*;
#(
  parameter int WORD_W        = 32,
  parameter int WORDS_PER_REC = 4,
  parameter int FIELD_DIGITS  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      char_valid,
  input  logic [7:0]                char_data,
  output logic                      mem_we,
  output logic [4*FIELD_DIGITS-1:0] mem_addr,
  output logic [WORD_W-1:0]         mem_wdata,
  output logic                      done,
  output logic [4*FIELD_DIGITS-1:0] start_addr,
  output logic                      trace_flag,
  output logic                      err_valid,
  output logic [2:0]                err_code
);
  localparam int FIELD_W   = 4 * FIELD_DIGITS;
  localparam int CNT_W     = FIELD_W + 1;
  localparam int MEM_DEPTH = 1 << FIELD_W;
  localparam int DPW       = WORD_W / 4;
  localparam int NIB_W     = (DPW > 1) ? $clog2(DPW) : 1;
  localparam int WIR_W     = (WORDS_PER_REC > 1) ? $clog2(WORDS_PER_REC) : 1;
  localparam int FD_W      = (FIELD_DIGITS > 1) ? $clog2(FIELD_DIGITS) : 1;

  // character classification
  logic       c_hex, c_lf, c_cr, c_blank;
  logic [3:0] c_nib;
  logic       take;

  loader_char_class u_class (
    .ch(char_data), .is_hex(c_hex), .nib(c_nib),
    .is_lf(c_lf), .is_cr(c_cr), .is_blank(c_blank)
  );

  assign take = char_valid & ~c_cr;

  ld_state_e            state, st_nx;
  logic [FD_W-1:0]      fd_cnt;
  logic [NIB_W-1:0]     nib_cnt;
  logic [WIR_W-1:0]     wir_cnt;
  logic [FIELD_W-1:0]   loc_q, len_q, start_q;
  logic                 flag_q;
  logic [CNT_W-1:0]     recs_left, wcnt, sum, recs_need;
  logic                 raise, in_field, fd_last, nib_last, wir_last, too_big;
  ld_err_e              code;

  // field and word assemblers
  logic [FIELD_W-1:0] field_next;
  logic [WORD_W-1:0]  word_next;

  assign in_field = (state == ST_HLOC) || (state == ST_HLEN) || (state == ST_TADR);

  loader_nibble_shift #(.W(FIELD_W)) u_field (
    .clk(clk), .rst(rst), .shift_en(take & c_hex & in_field),
    .nib(c_nib), .acc_next(field_next)
  );

  loader_nibble_shift #(.W(WORD_W)) u_word (
    .clk(clk), .rst(rst), .shift_en(take & c_hex & (state == ST_DATA)),
    .nib(c_nib), .acc_next(word_next)
  );

  // next-state and error decode
  always_comb begin
    fd_last   = (fd_cnt == FD_W'(FIELD_DIGITS - 1));
    nib_last  = (nib_cnt == NIB_W'(DPW - 1));
    wir_last  = (wir_cnt == WIR_W'(WORDS_PER_REC - 1));
    sum       = {1'b0, loc_q} + {1'b0, len_q};
    too_big   = (sum > CNT_W'(MEM_DEPTH));
    recs_need = ({1'b0, len_q} + CNT_W'(WORDS_PER_REC - 1)) / CNT_W'(WORDS_PER_REC);
    raise     = 1'b0;
    code      = ERR_NONE;
    st_nx     = state;
    unique case (state)
      ST_HLOC, ST_HLEN, ST_TADR: begin
        if (!c_hex) begin
          raise = 1'b1;
          code  = c_lf ? ERR_FORMAT : ERR_BADCHAR;
        end else if (fd_last) begin
          st_nx = (state == ST_HLOC) ? ST_HSEP :
                  (state == ST_HLEN) ? ST_HEOL : ST_TSEP;
        end
      end
      ST_HSEP, ST_TSEP: begin
        if (!c_blank) begin
          raise = 1'b1;
          code  = ERR_FORMAT;
        end else begin
          st_nx = (state == ST_HSEP) ? ST_HLEN : ST_TFLG;
        end
      end
      ST_HEOL: begin
        if (!c_lf) begin
          raise = 1'b1;
          code  = ERR_FORMAT;
        end else if (too_big) begin
          raise = 1'b1;
          code  = ERR_SIZE;
        end else begin
          st_nx = (recs_need == '0) ? ST_TADR : ST_DATA;
        end
      end
      ST_DATA: begin
        if (!c_hex) begin
          raise = 1'b1;
          code  = c_lf ? ERR_FORMAT : ERR_BADCHAR;
        end else if (nib_last && wir_last) begin
          st_nx = ST_DEOL;
        end
      end
      ST_DEOL: begin
        if (!c_lf) begin
          raise = 1'b1;
          code  = ERR_FORMAT;
        end else begin
          st_nx = (recs_left == CNT_W'(1)) ? ST_TADR : ST_DATA;
        end
      end
      ST_TFLG: begin
        if (!c_hex) begin
          raise = 1'b1;
          code  = c_lf ? ERR_FORMAT : ERR_BADCHAR;
        end else if (c_nib > 4'd1) begin
          raise = 1'b1;
          code  = ERR_TRACE;
        end else begin
          st_nx = ST_TEOL;
        end
      end
      ST_TEOL: begin
        if (!c_lf) begin
          raise = 1'b1;
          code  = ERR_FORMAT;
        end else begin
          st_nx = ST_HLOC;
        end
      end
      default: begin
        if (c_lf) st_nx = ST_HLOC;
      end
    endcase
  end

  // registered sequencing and outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_HLOC;
      fd_cnt     <= '0;
      nib_cnt    <= '0;
      wir_cnt    <= '0;
      loc_q      <= '0;
      len_q      <= '0;
      start_q    <= '0;
      flag_q     <= 1'b0;
      recs_left  <= '0;
      wcnt       <= '0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      done       <= 1'b0;
      start_addr <= '0;
      trace_flag <= 1'b0;
      err_valid  <= 1'b0;
      err_code   <= 3'd0;
    end else begin
      mem_we    <= 1'b0;
      done      <= 1'b0;
      err_valid <= 1'b0;
      if (take) begin
        if (raise) begin
          err_valid <= 1'b1;
          err_code  <= code;
          state     <= c_lf ? ST_HLOC : ST_DRAIN;
          fd_cnt    <= '0;
          nib_cnt   <= '0;
          wir_cnt   <= '0;
        end else begin
          state <= st_nx;
          if (in_field) begin
            fd_cnt <= fd_last ? '0 : fd_cnt + FD_W'(1);
            if (fd_last) begin
              if (state == ST_HLOC)      loc_q   <= field_next;
              else if (state == ST_HLEN) len_q   <= field_next;
              else                       start_q <= field_next;
            end
          end
          case (state)
            ST_HEOL: begin
              recs_left <= recs_need;
              wcnt      <= '0;
              nib_cnt   <= '0;
              wir_cnt   <= '0;
            end
            ST_DATA: begin
              nib_cnt <= nib_last ? '0 : nib_cnt + NIB_W'(1);
              if (nib_last) begin
                wir_cnt <= wir_last ? '0 : wir_cnt + WIR_W'(1);
                wcnt    <= wcnt + CNT_W'(1);
                if (wcnt < {1'b0, len_q}) begin
                  mem_we    <= 1'b1;
                  mem_addr  <= loc_q + wcnt[FIELD_W-1:0];
                  mem_wdata <= word_next;
                end
              end
            end
            ST_DEOL: recs_left <= recs_left - CNT_W'(1);
            ST_TFLG: flag_q    <= c_nib[0];
            ST_TEOL: begin
              done       <= 1'b1;
              start_addr <= start_q;
              trace_flag <= flag_q;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/hexrec_loader_checker.sv
`timescale 1ns/1ps
module hexrec_loader_checker #(
  parameter int FIELD_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               char_valid,
  input logic               mem_we,
  input logic               done,
  input logic [FIELD_W-1:0] start_addr,
  input logic               trace_flag,
  input logic               err_valid,
  input logic [2:0]         err_code
);
  assert_we_follows_char_R12: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(char_valid));

  assert_we_not_with_err_R12: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !err_valid);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_err_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !err_valid);

  assert_results_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(start_addr) && $stable(trace_flag)));

  assert_err_code_legal_R7: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> (err_code >= 3'd1 && err_code <= 3'd4));

  assert_err_follows_char_R11: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> $past(char_valid));
endmodule

bind hexrec_loader hexrec_loader_checker #(.FIELD_W(4 * FIELD_DIGITS)) u_checker (
  .clk(clk), .rst(rst), .char_valid(char_valid), .mem_we(mem_we),
  .done(done), .start_addr(start_addr), .trace_flag(trace_flag),
  .err_valid(err_valid), .err_code(err_code)
);

// File: tb/hexrec_loader_bench.sv
`timescale 1ns/1ps
module hexrec_loader_bench;
  localparam logic [31:0] SENT = 32'hA5A5_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        char_valid = 1'b0;
  logic [7:0]  char_data = 8'h00;
  logic        mem_we;
  logic [7:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic        done;
  logic [7:0]  start_addr;
  logic        trace_flag;
  logic        err_valid;
  logic [2:0]  err_code;

  hexrec_loader u_hexrec_loader (
    .clk(clk), .rst(rst), .char_valid(char_valid), .char_data(char_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .done(done), .start_addr(start_addr), .trace_flag(trace_flag),
    .err_valid(err_valid), .err_code(err_code)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int n_wr, n_done, n_err;
  logic [2:0]  last_err;
  logic [31:0] bmem [256];

  // monitor: outputs sampled on the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we) begin
        bmem[mem_addr] = mem_wdata;
        n_wr = n_wr + 1;
      end
      if (done) n_done = n_done + 1;
      if (err_valid) begin
        n_err = n_err + 1;
        last_err = err_code;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    for (int i = 0; i < 256; i++) bmem[i] = SENT;
    n_wr = 0; n_done = 0; n_err = 0; last_err = 3'd0;
  endtask

  task automatic put(input logic [7:0] c);
    @(negedge clk);
    char_valid = 1'b1;
    char_data  = c;
    @(negedge clk);
    char_valid = 1'b0;
  endtask

  task automatic send(input string s);
    for (int i = 0; i < s.len(); i++) put(s[i]);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "we in reset", {31'd0, mem_we}, 32'd0);
    chk("R1", "err in reset", {31'd0, err_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "done", {31'd0, done}, 32'd0);
    chk("R1", "start_addr", {24'd0, start_addr}, 32'd0);
    chk("R1", "trace_flag", {31'd0, trace_flag}, 32'd0);
    chk("R1", "we", {31'd0, mem_we}, 32'd0);
  endtask

  task automatic t_basic();
    clear_log();
    send("10 05\n");
    send("0123456");
    chk("R12", "we before 8th digit", {31'd0, mem_we}, 32'd0);
    put("7");
    chk("R12", "we after 8th digit", {31'd0, mem_we}, 32'd1);
    chk("R2", "first addr", {24'd0, mem_addr}, 32'h10);
    chk("R3", "first word", mem_wdata, 32'h0123_4567);
    send("89ABCDEFDEADBEEF00000001\n");
    send("CAFEF00D"); send("11111111"); send("22222222"); send("33333333\n");
    send("3A 1\n");
    settle();
    chk("R4", "write count len5", n_wr, 5);
    chk("R2", "word @11", bmem[8'h11], 32'h89AB_CDEF);
    chk("R2", "word @13", bmem[8'h13], 32'h0000_0001);
    chk("R2", "word @14", bmem[8'h14], 32'hCAFE_F00D);
    chk("R4", "padding @15 untouched", bmem[8'h15], SENT);
    chk("R6", "done pulses", n_done, 1);
    chk("R6", "start_addr", {24'd0, start_addr}, 32'h3A);
    chk("R6", "trace_flag", {31'd0, trace_flag}, 32'd1);
    chk("R7", "no errors", n_err, 0);
  endtask

  task automatic t_top_lower_cr();
    clear_log();
    send("f8 08\r\n");
    send("0badc0de\rfedcba9876543210c0ffee00\r\n");
    send("1234abcd"); send("00000000"); send("ffffffff"); send("5a5a5a5a\r\n");
    send("00 0\r\n");
    settle();
    chk("R9", "sum 256 accepted, writes", n_wr, 8);
    chk("R3", "lower case word @F8", bmem[8'hF8], 32'h0BAD_C0DE);
    chk("R5", "CR inside line @F9", bmem[8'hF9], 32'hFEDC_BA98);
    chk("R3", "word @FC", bmem[8'hFC], 32'h1234_ABCD);
    chk("R2", "last word @FF", bmem[8'hFF], 32'h5A5A_5A5A);
    chk("R5", "no errors with CR", n_err, 0);
    chk("R6", "done", n_done, 1);
    chk("R6", "start 00", {24'd0, start_addr}, 32'h00);
    chk("R6", "trace 0", {31'd0, trace_flag}, 32'd0);
  endtask

  task automatic t_zero_len();
    clear_log();
    send("20 00\n41 1\n");
    settle();
    chk("R4", "len0 writes", n_wr, 0);
    chk("R4", "len0 done", n_done, 1);
    chk("R4", "len0 start", {24'd0, start_addr}, 32'h41);
    chk("R6", "len0 trace", {31'd0, trace_flag}, 32'd1);
  endtask

  task automatic t_too_large();
    clear_log();
    send("F9 08\n");
    settle();
    chk("R9", "error count", n_err, 1);
    chk("R9", "error code", {29'd0, last_err}, 32'd3);
    chk("R9", "no write", n_wr, 0);
    send("00 01\nABCDEF01"); send("00000000"); send("00000000"); send("00000000\n");
    send("05 0\n");
    settle();
    chk("R11", "recovered write", bmem[8'h00], 32'hABCD_EF01);
    chk("R11", "recovered done", n_done, 1);
    chk("R11", "recovered start", {24'd0, start_addr}, 32'h05);
  endtask

  task automatic t_bad_char();
    clear_log();
    send("12 0G34\n");
    send("02 01\n11112222"); send("00000000"); send("00000000"); send("00000000\n");
    send("06 1\n");
    settle();
    chk("R7", "error count", n_err, 1);
    chk("R7", "error code", {29'd0, last_err}, 32'd1);
    chk("R11", "write after drain", bmem[8'h02], 32'h1111_2222);
    chk("R11", "writes after drain", n_wr, 1);
    chk("R11", "done after drain", n_done, 1);
  endtask

  task automatic t_format();
    clear_log();
    send("12-04\n");
    send("03 01\n77778888"); send("00000000"); send("00000000"); send("00000000\n");
    send("07 1\n");
    settle();
    chk("R8", "error count", n_err, 1);
    chk("R8", "error code bad blank", {29'd0, last_err}, 32'd2);
    chk("R11", "write", bmem[8'h03], 32'h7777_8888);
    chk("R11", "start", {24'd0, start_addr}, 32'h07);
  endtask

  task automatic t_trace_bad();
    clear_log();
    send("00 00\n07 2\n");
    settle();
    chk("R10", "error code", {29'd0, last_err}, 32'd4);
    chk("R10", "no done", n_done, 0);
    chk("R10", "start held", {24'd0, start_addr}, 32'h07);
    chk("R10", "trace held", {31'd0, trace_flag}, 32'd1);
  endtask

  task automatic t_short_line();
    clear_log();
    send("30 04\n0123\n");
    send("40 01\n89ABCDEF"); send("00000000"); send("00000000"); send("00000000\n");
    send("7F 1\n");
    settle();
    chk("R8", "early LF error count", n_err, 1);
    chk("R8", "early LF code", {29'd0, last_err}, 32'd2);
    chk("R11", "header right after LF error", bmem[8'h40], 32'h89AB_CDEF);
    chk("R11", "single write", n_wr, 1);
    chk("R6", "start 7F", {24'd0, start_addr}, 32'h7F);
  endtask

  bit finished = 0;

  initial begin
    clear_log();
    t_reset();
    t_basic();
    t_top_lower_cr();
    t_zero_len();
    t_too_large();
    t_bad_char();
    t_format();
    t_trace_bad();
    t_short_line();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule